// File: doc/BRIEF.md
# Parallel Weighted Keyword Relevance Scorer

The block reads a document one byte at a time and scores how relevant it is to a list of keywords. The keyword list is loadable. Each keyword sits in its own slot, and every slot has a private comparator, a weight and a mode bit. All slots follow the same incoming word together.

A slot judges the word when that word ends. In exact mode the word must equal the stored keyword. In root mode it is enough that the word starts with the keyword. Letters are compared without regard to case. Each time a word ends, the weights of all slots that hit are added to a running total. This happens while the text is still arriving, so no second pass over the document is needed.

A beat flagged as end of document does three things: it closes the open word, it publishes the final score with a one-cycle done pulse, and it zeroes the total for the next document. Keywords are rewritten between searches through a simple write port. The slot hardware does not change when they are.

Top module: `kw_relevance_scorer`

## Requirements
- R1: After reset `score_o` is 0, `done_o` is 0 and `ch_ready_o` is 1. Every slot holds a zero-length keyword, so no document scores anything until slots are written.
- R2: In exact mode (`cfg_prefix_i`=0) a slot hits only when the closed word has exactly the keyword's length and the same characters. A word shorter or longer than the keyword does not hit, and neither does any word of more than 16 characters.
- R3: In root mode (`cfg_prefix_i`=1) a slot hits when the closed word begins with the keyword, including a word equal to it. A word shorter than the keyword does not hit.
- R4: Before comparison, the bytes 0x41 to 0x5A are folded to 0x61 to 0x7A, both in the stored keyword and in the document.
- R5: Word characters are a–z, A–Z and 0–9. Every other byte ends the current word. Runs of delimiters form empty words, and an empty word never hits.
- R6: When several slots hit on the same word, all of their weights are added to the total for that word.
- R7: Every occurrence of a keyword in a document adds its weight again.
- R8: The 16-bit total saturates at 65535 and never wraps.
- R9: An accepted beat with `ch_last_i`=1 ends the document. Its data byte is not part of any word, and it closes the open word. On the next cycle `done_o` is high for exactly one cycle and `score_o` shows the final total. `score_o` keeps that value until the next end of document. The next document starts from 0.
- R10: A slot written with length 0 never hits, whatever its weight.
- R11: `ch_ready_o` is low while `cfg_we_i` is high. A byte presented while `ch_ready_o` is low is not consumed.
- R12: A write with `cfg_we_i`=1 replaces the keyword, length, weight and mode of slot `cfg_slot_i`. Keyword character k (k=0 first) sits in `cfg_pattern_i[8k+7:8k]`. A length above 16 is limited to 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ch_valid_i | input | 1 | Document byte valid |
| ch_data_i | input | 8 | Document byte |
| ch_last_i | input | 1 | End-of-document marker for this beat |
| ch_ready_o | output | 1 | Byte accepted when high together with valid |
| cfg_we_i | input | 1 | Slot write strobe |
| cfg_slot_i | input | 3 | Slot index to write |
| cfg_pattern_i | input | 128 | Keyword bytes, character k at bits 8k+7:8k |
| cfg_len_i | input | 5 | Keyword length, 0 disables the slot |
| cfg_weight_i | input | 8 | Unsigned slot weight |
| cfg_prefix_i | input | 1 | 1 = root match, 0 = exact match |
| score_o | output | 16 | Final score of the last completed document |
| done_o | output | 1 | One-cycle pulse when score_o is updated |

## Verification
Slot state is only visible through the score, and only at the end of a document. Suppose a slot keeps a stale match flag or a wrong position count after a word ends. The bench sees nothing until the next end-of-document beat, and then only as a score that differs by that slot's weight. For this reason the document table is built so that each slot and mode gives a distinct weight sum, which lets a wrong slot be told apart from a right one. A fault in the accumulator, such as a missed clear or a wrapped sum, shows up one cycle after the end marker of the document in which it occurs.

// File: rtl/kw_pkg.sv
package kw_pkg;
  function automatic logic is_word_char(logic [7:0] c);
    return (c >= 8'h61 && c <= 8'h7a) || (c >= 8'h41 && c <= 8'h5a) ||
           (c >= 8'h30 && c <= 8'h39);
  endfunction

  function automatic logic [7:0] fold_case(logic [7:0] c);
    return (c >= 8'h41 && c <= 8'h5a) ? (c | 8'h20) : c;
  endfunction
endpackage

// File: rtl/kw_slot.sv
module kw_slot import kw_pkg::*; #(
  parameter int MAX_LEN = 16,
  parameter int W_W     = 8,
  localparam int LEN_W  = $clog2(MAX_LEN + 1),
  localparam int POS_W  = $clog2(MAX_LEN + 2),
  localparam int IDX_W  = $clog2(MAX_LEN)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_i,
  input  logic [MAX_LEN*8-1:0] pat_i,
  input  logic [LEN_W-1:0]     len_i,
  input  logic [W_W-1:0]       weight_i,
  input  logic                 prefix_i,
  input  logic [7:0]           ch_i,
  input  logic                 char_i,
  input  logic                 bound_i,
  output logic                 hit_o,
  output logic [W_W-1:0]       weight_o
);
  localparam logic [POS_W-1:0] POS_MAX = POS_W'(MAX_LEN + 1);

  logic [7:0]       pat_q [MAX_LEN];
  logic [LEN_W-1:0] len_q;
  logic [W_W-1:0]   weight_q;
  logic             prefix_q;
  logic [POS_W-1:0] pos_q;
  logic             alive_q;
  logic [POS_W-1:0] len_x;
  logic             ch_ok;

  assign len_x = POS_W'(len_q);

  always_comb begin
    if (pos_q < len_x) ch_ok = (pat_q[pos_q[IDX_W-1:0]] == ch_i);
    else               ch_ok = prefix_q; // past the keyword: only root mode survives
  end

  assign hit_o    = bound_i & alive_q & (len_q != '0) &
                    (prefix_q ? (pos_q >= len_x) : (pos_q == len_x));
  assign weight_o = hit_o ? weight_q : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < MAX_LEN; k++) pat_q[k] <= '0;
      len_q    <= '0;
      weight_q <= '0;
      prefix_q <= 1'b0;
      pos_q    <= '0;
      alive_q  <= 1'b1;
    end else if (wr_i) begin
      for (int k = 0; k < MAX_LEN; k++) pat_q[k] <= fold_case(pat_i[8*k +: 8]);
      len_q    <= (len_i > LEN_W'(MAX_LEN)) ? LEN_W'(MAX_LEN) : len_i;
      weight_q <= weight_i;
      prefix_q <= prefix_i;
      pos_q    <= '0;
      alive_q  <= 1'b1;
    end else if (bound_i) begin
      pos_q   <= '0;
      alive_q <= 1'b1;
    end else if (char_i) begin
      alive_q <= alive_q & ch_ok;
      if (pos_q != POS_MAX) pos_q <= pos_q + 1'b1;
    end
  end
endmodule

// File: rtl/kw_accum.sv
module kw_accum #(
  parameter int N   = 8,
  parameter int W_W = 8,
  parameter int S_W = 16,
  localparam int SUM_W = W_W + $clog2(N + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [N-1:0][W_W-1:0] wt_i,
  input  logic                add_i,
  input  logic                last_i,
  output logic [S_W-1:0]      acc_o,
  output logic [S_W-1:0]      score_o,
  output logic                done_o
);
  localparam logic [S_W-1:0] S_MAX = '1;

  logic [SUM_W-1:0] sum;
  logic [S_W:0]     total;
  logic [S_W-1:0]   sat;
  logic [S_W-1:0]   acc_q;

  always_comb begin
    sum = '0;
    for (int i = 0; i < N; i++) sum = sum + SUM_W'(wt_i[i]);
  end

  assign total = {1'b0, acc_q} + (S_W + 1)'(sum);
  assign sat   = total[S_W] ? S_MAX : total[S_W-1:0];
  assign acc_o = acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q   <= '0;
      score_o <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (add_i) begin
        if (last_i) begin
          score_o <= sat;
          done_o  <= 1'b1;
          acc_q   <= '0;
        end else begin
          acc_q <= sat;
        end
      end
    end
  end
endmodule

// File: rtl/kw_relevance_scorer.sv
module kw_relevance_scorer import kw_pkg::*; #(
  parameter int N_SLOTS  = 8,
  parameter int MAX_LEN  = 16,
  parameter int W_WIDTH  = 8,
  parameter int S_WIDTH  = 16,
  localparam int SLOT_W  = $clog2(N_SLOTS),
  localparam int LEN_W   = $clog2(MAX_LEN + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 ch_valid_i,
  input  logic [7:0]           ch_data_i,
  input  logic                 ch_last_i,
  output logic                 ch_ready_o,
  input  logic                 cfg_we_i,
  input  logic [SLOT_W-1:0]    cfg_slot_i,
  input  logic [MAX_LEN*8-1:0] cfg_pattern_i,
  input  logic [LEN_W-1:0]     cfg_len_i,
  input  logic [W_WIDTH-1:0]   cfg_weight_i,
  input  logic                 cfg_prefix_i,
  output logic [S_WIDTH-1:0]   score_o,
  output logic                 done_o
);
  logic                            ch_fire;
  logic                            word_ch;
  logic                            char_ev;
  logic                            bound_ev;
  logic [7:0]                      ch_fold;
  logic [N_SLOTS-1:0]              slot_hit;
  logic [N_SLOTS-1:0][W_WIDTH-1:0] slot_wt;
  logic [S_WIDTH-1:0]              acc;

  // config has priority over the stream
  assign ch_ready_o = ~cfg_we_i;
  assign ch_fire    = ch_valid_i & ch_ready_o;
  assign word_ch    = is_word_char(ch_data_i);
  assign char_ev    = ch_fire & ~ch_last_i & word_ch;
  assign bound_ev   = ch_fire & (ch_last_i | ~word_ch);
  assign ch_fold    = fold_case(ch_data_i);

  for (genvar g = 0; g < N_SLOTS; g++) begin : g_slot
    kw_slot #(.MAX_LEN(MAX_LEN), .W_W(W_WIDTH)) u_slot (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_i     (cfg_we_i && (cfg_slot_i == SLOT_W'(g))),
      .pat_i    (cfg_pattern_i),
      .len_i    (cfg_len_i),
      .weight_i (cfg_weight_i),
      .prefix_i (cfg_prefix_i),
      .ch_i     (ch_fold),
      .char_i   (char_ev),
      .bound_i  (bound_ev),
      .hit_o    (slot_hit[g]),
      .weight_o (slot_wt[g])
    );
  end

  kw_accum #(.N(N_SLOTS), .W_W(W_WIDTH), .S_W(S_WIDTH)) u_accum (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wt_i    (slot_wt),
    .add_i   (bound_ev),
    .last_i  (ch_last_i),
    .acc_o   (acc),
    .score_o (score_o),
    .done_o  (done_o)
  );
endmodule

// File: rtl/kw_relevance_scorer_chk.sv
module kw_relevance_scorer_chk #(
  parameter int N_SLOTS = 8,
  parameter int S_W     = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               fire_i,
  input logic               last_i,
  input logic               done_i,
  input logic [S_W-1:0]     score_i,
  input logic [S_W-1:0]     acc_i,
  input logic [N_SLOTS-1:0] hit_i
);
  a_r9_done_follows_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_i && last_i) |=> done_i);

  a_r9_no_stray_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fire_i && last_i) |=> !done_i);

  a_r9_score_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_i |-> $stable(score_i));

  a_r9_acc_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_i && last_i) |=> (acc_i == '0));

  a_r8_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fire_i && last_i) |=> (acc_i >= $past(acc_i)));

  a_r5_hit_needs_beat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_i != '0) |-> fire_i);
endmodule

bind kw_relevance_scorer kw_relevance_scorer_chk #(.N_SLOTS(N_SLOTS), .S_W(S_WIDTH)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .fire_i  (ch_fire),
  .last_i  (ch_last_i),
  .done_i  (done_o),
  .score_i (score_o),
  .acc_i   (acc),
  .hit_i   (slot_hit)
);

// File: tb/kw_relevance_scorer_bench.sv
module kw_relevance_scorer_bench;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         ch_valid_i = 1'b0;
  logic [7:0]   ch_data_i = '0;
  logic         ch_last_i = 1'b0;
  logic         ch_ready_o;
  logic         cfg_we_i = 1'b0;
  logic [2:0]   cfg_slot_i = '0;
  logic [127:0] cfg_pattern_i = '0;
  logic [4:0]   cfg_len_i = '0;
  logic [7:0]   cfg_weight_i = '0;
  logic         cfg_prefix_i = 1'b0;
  logic [15:0]  score_o;
  logic         done_o;

  int errors = 0;
  int checks = 0;

  always #5 clk_i = ~clk_i;

  kw_relevance_scorer u_kw_relevance_scorer (.*);

  localparam int NV = 12;
  localparam logic [8*24-1:0] DOCS [NV] = '{
    "data", "DATA", "database", "dat", "computer computing", "fpga,fpga;FPGA",
    "x1 x2", "x1x", "  ..data!!", "fpgadata", "comput", "datum"};
  localparam int EXP [NV] = '{13, 13, 3, 0, 40, 15, 7, 0, 13, 0, 20, 0};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cfg(input int slot, input logic [127:0] s, input int n,
                     input int w, input bit pfx);
    logic [127:0] p = '0;
    for (int k = 0; k < n; k++) p[8*k +: 8] = s[8*(n-1-k) +: 8];
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_slot_i = 3'(slot); cfg_pattern_i = p;
    cfg_len_i = 5'(n); cfg_weight_i = 8'(w); cfg_prefix_i = pfx;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  task automatic beat(input logic [7:0] c);
    @(negedge clk_i);
    ch_valid_i = 1'b1; ch_data_i = c; ch_last_i = 1'b0;
  endtask

  task automatic send_str(input logic [8*24-1:0] s);
    for (int k = 23; k >= 0; k--)
      if (s[8*k +: 8] != 8'h00) beat(s[8*k +: 8]);
  endtask

  // end marker carries a letter that must not join the word (R9)
  task automatic finish_doc(input int exp, input string req);
    @(negedge clk_i);
    ch_valid_i = 1'b1; ch_data_i = "s"; ch_last_i = 1'b1;
    @(negedge clk_i);
    ch_valid_i = 1'b0; ch_last_i = 1'b0;
    chk(done_o === 1'b1, "R9 done", int'(done_o), 1);
    chk(score_o === 16'(exp), req, int'(score_o), exp);
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #23 rst_ni = 1'b1;
    @(negedge clk_i);
    chk(score_o === 16'd0, "R1 score", int'(score_o), 0);
    chk(done_o === 1'b0, "R1 done", int'(done_o), 0);
    chk(ch_ready_o === 1'b1, "R1 ready", int'(ch_ready_o), 1);
    send_str("data data");
    finish_doc(0, "R1 slots empty");

    cfg(0, "data", 4, 10, 1'b0);
    cfg(1, "comput", 6, 20, 1'b1);
    cfg(2, "fpga", 4, 5, 1'b0);
    cfg(3, "", 0, 99, 1'b0);     // R10 disabled slot
    cfg(4, "DaTa", 4, 3, 1'b1);  // folded on load, R4
    cfg(5, "x1", 2, 7, 1'b0);

    for (int v = 0; v < NV; v++) begin
      send_str(DOCS[v]);
      finish_doc(EXP[v], $sformatf("R2/R3/R5/R6/R7 doc %0d", v));
    end

    // R9 pulse width and hold
    @(negedge clk_i);
    chk(done_o === 1'b0, "R9 pulse width", int'(done_o), 0);
    repeat (3) @(negedge clk_i);
    chk(score_o === 16'd0, "R9 score held", int'(score_o), 0);

    // R11: byte under a config write is not consumed
    beat("d"); beat("a");
    @(negedge clk_i);
    ch_valid_i = 1'b1; ch_data_i = "x";
    cfg_we_i = 1'b1; cfg_slot_i = 3'd7; cfg_pattern_i = {112'd0, "zz"};
    cfg_len_i = 5'd2; cfg_weight_i = 8'd1; cfg_prefix_i = 1'b0;
    #1;
    chk(ch_ready_o === 1'b0, "R11 ready low", int'(ch_ready_o), 0);
    @(negedge clk_i);
    cfg_we_i = 1'b0; ch_data_i = "t";
    beat("a");
    finish_doc(13, "R11 byte not consumed");

    // R10: zero-length slot with large weight, word "" and "data"
    send_str("?? data");
    finish_doc(13, "R10 empty slot no hit");

    // R12 rewrite slot 2 to root mode
    cfg(2, "fpga", 4, 1, 1'b1);
    send_str("fpgas fpga");
    finish_doc(2, "R12 rewrite slot");

    // R2: word over 16 chars never hits exact slot
    cfg(6, "aaaaaaaaaaaaaaaa", 16, 50, 1'b0);
    send_str("aaaaaaaaaaaaaaaaa");
    finish_doc(0, "R2 overlong word");
    send_str("aaaaaaaaaaaaaaaa");
    finish_doc(50, "R2 full length word");

    // R8 saturation
    for (int s = 0; s < 8; s++) cfg(s, "a", 1, 255, 1'b0);
    for (int w = 0; w < 33; w++) begin beat("a"); beat(" "); end
    finish_doc(65535, "R8 saturate");
    send_str("a");
    finish_doc(2040, "R9 accumulator cleared");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule